// File: doc/BRIEF.md
# Timestamp-Domain Clock Recovery Loop

This block recovers a clock from a stream of measured data-edge times. It works only on edge timestamp arithmetic and has no oscillator. Each incoming edge time is rounded to a whole number of unit intervals after the last recovered clock edge. The clock prediction moves forward by that many corrected periods, and the signed distance between the measured edge and the prediction becomes the phase error for that edge.

The error goes through a first-order IIR low-pass filter. The filter's cutoff is the data rate divided by an integer divisor, and the divisor has a floor of 20. The filter output, scaled down to time units, is added to the nominal period to give the corrected period used for the next edge. Two kinds of edge are dropped with a flag and leave the loop state untouched: an edge too close to the last clock edge, and an edge after a run longer than the allowed maximum. Every input edge gives exactly one output strobe, a fixed number of cycles later.

Top module: `edge_clock_recovery`

## Requirements
- R1: While reset is held and after it is released, `out_valid`, `out_skip`, `out_time` and `out_err` are zero. The internal last-clock time and the correction also start at zero.
- R2: With no correction yet applied, the first accepted edge is predicted one nominal period after time zero. An edge measured at exactly `nominal_period` therefore reports `out_time = nominal_period` and `out_err = 0`.
- R3: The unit-interval count is n = round(d / P), where d is the edge time minus the last clock time and P is the corrected period. An exact half rounds up. The reported clock time is last + n·P, and it becomes the new last clock time.
- R4: `out_err` is the signed edge time minus the reported clock time. For an accepted edge, 2·err lies in [−P, P).
- R5: The correction y has 8 fractional bits. On each accepted edge with error x it becomes y + floor(((x·256 − y)·floor(65536/n)) / 65536). The corrected period is P = nominal_period + floor(y/256).
- R6: A `cutoff_div` value below 20 acts exactly as 20.
- R7: An edge is skipped when 2·d < P (this includes negative d) or when 2·d ≥ 17·P (more than 8 unit intervals at the default maximum run). A skipped edge reports `out_skip = 1`, `out_err = 0` and `out_time` equal to the last clock time, and it leaves both the last clock time and the correction unchanged.
- R8: Each cycle with `in_valid` high gives exactly one `out_valid` pulse, two clock cycles later. Edges on back-to-back cycles are allowed, and `out_valid` is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A measured data edge is present |
| in_time | input | TW (32) | Measured edge timestamp, unsigned time units |
| nominal_period | input | PW (16) | Nominal unit interval in time units |
| cutoff_div | input | DW (8) | Loop cutoff divisor n, clamped to at least 20 |
| out_valid | output | 1 | One strobe per input edge |
| out_time | output | TW (32) | Recovered clock-edge time |
| out_err | output | EW (16) | Signed phase error, zero when skipped |
| out_skip | output | 1 | The edge was rejected as too early or too late |

## Verification
Four properties are checked on every cycle: the fixed two-cycle strobe latency in both directions, the half-period error window and unit-interval range of each accepted edge, the held clock time on skipped edges, and the bound on the reciprocal that the divisor clamp implies. The scenarios alone show the numeric results: the rounding of exact halves, the convergence of the filter under a constant phase offset, the equivalence of small divisors to 20, and the exact skip boundaries at half a period and at the maximum run. For these, a behavioural model in the bench is compared against the design on every clock.

// File: rtl/ecr_pkg.sv
package ecr_pkg;
  // fractional bits carried by the loop correction
  localparam int GUARD = 8;
  // fractional bits of the divisor reciprocal
  localparam int RCP_BITS = 16;

  typedef enum logic [1:0] {
    VERD_NONE  = 2'd0,
    VERD_TAKE  = 2'd1,
    VERD_EARLY = 2'd2,
    VERD_LATE  = 2'd3
  } verdict_t;
endpackage

// File: rtl/ecr_div_clamp.sv
module ecr_div_clamp #(
  parameter int DW      = 8,
  parameter int MIN_DIV = 20,
  parameter int RB      = 16
) (
  input  logic [DW-1:0] div_in,
  output logic [RB:0]   rcp
);
  logic [DW-1:0] div_eff;

  // floor(2^RB / n) by restoring division, one quotient bit per step
  function automatic logic [RB:0] recip(input logic [DW-1:0] n);
    logic [DW:0] rem;
    logic [RB:0] q;
    rem = '0;
    q   = '0;
    for (int i = RB; i >= 0; i--) begin
      rem = {rem[DW-1:0], 1'(i == RB)};
      if (rem >= {1'b0, n}) begin
        rem  = rem - {1'b0, n};
        q[i] = 1'b1;
      end
    end
    return q;
  endfunction

  // R6: small divisors behave as the minimum
  assign div_eff = (div_in < DW'(MIN_DIV)) ? DW'(MIN_DIV) : div_in;
  assign rcp     = recip(div_eff);
endmodule

// File: rtl/ecr_ui_count.sv
module ecr_ui_count #(
  parameter int TW      = 32,
  parameter int PERW    = 18,
  parameter int MAX_RUN = 8,
  parameter int CW      = 4
) (
  input  logic signed [TW-1:0]   delta,
  input  logic signed [PERW-1:0] period,
  output logic [CW-1:0]          n_ui,
  output logic                   early,
  output logic                   late
);
  localparam int XW = TW + PERW + 2;
  localparam logic signed [XW-1:0] LIM = XW'(2 * MAX_RUN + 1);

  logic signed [XW-1:0] d2;
  logic signed [XW-1:0] per_x;
  logic [MAX_RUN-1:0]   hit;

  assign d2    = XW'(delta) <<< 1;
  assign per_x = XW'(period);

  // threshold k sits at (k - 1/2) periods; ties round up
  for (genvar gk = 1; gk <= MAX_RUN; gk++) begin : g_thr
    localparam logic signed [XW-1:0] ODD = XW'(2 * gk - 1);
    assign hit[gk-1] = (d2 >= ODD * per_x);
  end

  always_comb begin
    n_ui = '0;
    for (int i = 0; i < MAX_RUN; i++) n_ui = n_ui + CW'(hit[i]);
  end

  assign early = !hit[0];
  assign late  = (d2 >= LIM * per_x);
endmodule

// File: rtl/ecr_loop_filter.sv
module ecr_loop_filter
  import ecr_pkg::*;
#(
  parameter int EW = 16,
  parameter int PW = 16,
  parameter int RB = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd,
  input  logic signed [EW-1:0] err,
  input  logic [RB:0]          rcp,
  input  logic [PW-1:0]        nominal,
  output logic signed [PW+1:0] period
);
  localparam int YW   = EW + GUARD;
  localparam int DFW  = YW + 1;
  localparam int PRW  = DFW + RB + 2;
  localparam int PERW = PW + 2;

  logic signed [YW-1:0] corr_q;

  // y + (x - y)/n, with 1/n as a fixed-point reciprocal
  function automatic logic signed [YW-1:0] iir_next(
    input logic signed [YW-1:0] y,
    input logic signed [EW-1:0] x,
    input logic [RB:0]          r
  );
    logic signed [DFW-1:0] scaled;
    logic signed [DFW-1:0] diff;
    logic signed [PRW-1:0] prod;
    scaled = DFW'(x) <<< GUARD;
    diff   = scaled - DFW'(y);
    prod   = PRW'(diff) * PRW'($signed({1'b0, r}));
    return y + YW'(prod >>> RB);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   corr_q <= '0;
    else if (upd) corr_q <= iir_next(corr_q, err, rcp);
  end

  assign period = $signed({2'b00, nominal}) + PERW'(corr_q >>> GUARD);
endmodule

// File: rtl/edge_clock_recovery.sv
module edge_clock_recovery
  import ecr_pkg::*;
#(
  parameter int TW      = 32,
  parameter int PW      = 16,
  parameter int EW      = 16,
  parameter int DW      = 8,
  parameter int MIN_DIV = 20,
  parameter int MAX_RUN = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [TW-1:0]        in_time,
  input  logic [PW-1:0]        nominal_period,
  input  logic [DW-1:0]        cutoff_div,
  output logic                 out_valid,
  output logic [TW-1:0]        out_time,
  output logic signed [EW-1:0] out_err,
  output logic                 out_skip
);
  localparam int RB   = RCP_BITS;
  localparam int PERW = PW + 2;
  localparam int CW   = $clog2(MAX_RUN + 1);

  // ---------------- stage A: capture edge and settings ----------------
  logic          a_valid;
  logic [TW-1:0] a_time;
  logic [PW-1:0] a_nom;
  logic [RB:0]   a_rcp;
  logic [RB:0]   rcp_now;

  ecr_div_clamp #(.DW(DW), .MIN_DIV(MIN_DIV), .RB(RB)) u_div (
    .div_in (cutoff_div),
    .rcp    (rcp_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_valid <= 1'b0;
      a_time  <= '0;
      a_nom   <= '0;
      a_rcp   <= '0;
    end else begin
      a_valid <= in_valid;
      if (in_valid) begin
        a_time <= in_time;
        a_nom  <= nominal_period;
        a_rcp  <= rcp_now;
      end
    end
  end

  // ---------------- stage B: count, predict, filter ----------------
  function automatic logic [TW-1:0] advance(
    input logic [TW-1:0]          base,
    input logic [CW-1:0]          n,
    input logic signed [PERW-1:0] per
  );
    return base + TW'(n) * TW'($unsigned(per));
  endfunction

  function automatic logic signed [TW-1:0] phase_err(
    input logic [TW-1:0] meas,
    input logic [TW-1:0] pred
  );
    return $signed(meas - pred);
  endfunction

  logic [TW-1:0]          clk_q;
  logic signed [PERW-1:0] b_period;
  logic signed [TW-1:0]   b_delta;
  logic [CW-1:0]          b_nui;
  logic                   b_early;
  logic                   b_late;
  logic [TW-1:0]          b_pred;
  logic signed [TW-1:0]   b_err_full;
  logic signed [EW-1:0]   b_err;
  verdict_t               b_verdict;
  logic                   b_accept;

  assign b_delta = $signed(a_time - clk_q);

  ecr_ui_count #(.TW(TW), .PERW(PERW), .MAX_RUN(MAX_RUN), .CW(CW)) u_ui (
    .delta  (b_delta),
    .period (b_period),
    .n_ui   (b_nui),
    .early  (b_early),
    .late   (b_late)
  );

  assign b_pred     = advance(clk_q, b_nui, b_period);
  assign b_err_full = phase_err(a_time, b_pred);
  assign b_err      = EW'(b_err_full);

  always_comb begin
    if (!a_valid)     b_verdict = VERD_NONE;
    else if (b_early) b_verdict = VERD_EARLY;
    else if (b_late)  b_verdict = VERD_LATE;
    else              b_verdict = VERD_TAKE;
  end
  assign b_accept = (b_verdict == VERD_TAKE);

  ecr_loop_filter #(.EW(EW), .PW(PW), .RB(RB)) u_lf (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (b_accept),
    .err     (b_err),
    .rcp     (a_rcp),
    .nominal (a_nom),
    .period  (b_period)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_q     <= '0;
      out_valid <= 1'b0;
      out_time  <= '0;
      out_err   <= '0;
      out_skip  <= 1'b0;
    end else begin
      out_valid <= a_valid;
      if (b_accept) clk_q <= b_pred;
      if (a_valid) begin
        out_skip <= !b_accept;
        out_time <= b_accept ? b_pred : clk_q;
        out_err  <= b_accept ? b_err : '0;
      end
    end
  end
endmodule

// File: rtl/edge_clock_recovery_chk.sv
module edge_clock_recovery_chk #(
  parameter int TW      = 32,
  parameter int PW      = 16,
  parameter int EW      = 16,
  parameter int MIN_DIV = 20,
  parameter int MAX_RUN = 8,
  parameter int CW      = 4,
  parameter int RB      = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic                 out_skip,
  input logic [TW-1:0]        out_time,
  input logic signed [EW-1:0] out_err,
  input logic                 accept,
  input logic [CW-1:0]        nui,
  input logic signed [TW-1:0] err_full,
  input logic signed [PW+1:0] period,
  input logic                 a_valid,
  input logic [RB:0]          a_rcp
);
  localparam logic [RB:0] RCP_CAP = (RB+1)'((64'd1 << RB) / MIN_DIV);

  logic signed [TW+1:0] e2;
  logic signed [TW+1:0] pw;
  assign e2 = (TW+2)'(err_full) <<< 1;
  assign pw = (TW+2)'(period);

  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && !out_skip && out_time == '0 && out_err == '0));

  p_strobe_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  p_skip_holds_time_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_skip) |-> $stable(out_time));

  p_err_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (e2 >= -pw && e2 < pw));

  p_run_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (nui >= CW'(1) && nui <= CW'(MAX_RUN)));

  p_rcp_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid |-> (a_rcp <= RCP_CAP));
endmodule

bind edge_clock_recovery edge_clock_recovery_chk #(
  .TW(TW), .PW(PW), .EW(EW), .MIN_DIV(MIN_DIV), .MAX_RUN(MAX_RUN),
  .CW(CW), .RB(RB)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_skip  (out_skip),
  .out_time  (out_time),
  .out_err   (out_err),
  .accept    (b_accept),
  .nui       (b_nui),
  .err_full  (b_err_full),
  .period    (b_period),
  .a_valid   (a_valid),
  .a_rcp     (a_rcp)
);

// File: tb/sim_edge_clock_recovery.sv
module sim_edge_clock_recovery;
  localparam int TW = 32, PW = 16, EW = 16, DW = 8;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [TW-1:0] in_time = '0;
  logic [PW-1:0] nominal_period = PW'(1000);
  logic [DW-1:0] cutoff_div = DW'(20);
  logic out_valid, out_skip;
  logic [TW-1:0] out_time;
  logic signed [EW-1:0] out_err;

  always #4 clk = ~clk;

  edge_clock_recovery u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_time(in_time),
    .nominal_period(nominal_period), .cutoff_div(cutoff_div),
    .out_valid(out_valid), .out_time(out_time), .out_err(out_err),
    .out_skip(out_skip)
  );

  int total = 0, bad = 0;
  int nom = 1000, dv = 20;
  longint m_clk = 0, m_y = 0;
  // index 0: just driven, index 1: due at the outputs now
  bit pv[2]; longint pt[2]; longint pe[2]; bit ps[2]; string ptag[2];

  function automatic longint cur_p();
    return longint'(nom) + (m_y >>> 8);
  endfunction

  task automatic check_eq(input string tag, input string what,
                          input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // behavioural model of one edge, in whole-number arithmetic
  task automatic model(input longint t, input string tag);
    longint p, d, n, pred, e, rc;
    int dve;
    p = cur_p();
    d = t - m_clk;
    dve = (dv < 20) ? 20 : dv;
    pv[0] = 1; ptag[0] = tag;
    if (2 * d < p || 2 * d >= 17 * p) begin
      pt[0] = m_clk; pe[0] = 0; ps[0] = 1;
    end else begin
      n = (2 * d + p) / (2 * p);
      pred = m_clk + n * p;
      e = t - pred;
      rc = 65536 / dve;
      m_y = m_y + ((((e * 256) - m_y) * rc) >>> 16);
      m_clk = pred;
      pt[0] = pred; pe[0] = e; ps[0] = 0;
    end
  endtask

  task automatic tick(input bit v, input longint t, input string tag);
    @(negedge clk);
    check_eq("R8", "out_valid", longint'(out_valid), longint'(pv[1]));
    if (pv[1] && out_valid) begin
      check_eq(ptag[1], "out_time", longint'(out_time), pt[1]);
      check_eq(ptag[1], "out_err", longint'($signed(out_err)), pe[1]);
      check_eq(ptag[1], "out_skip", longint'(out_skip), longint'(ps[1]));
    end
    pv[1] = pv[0]; pt[1] = pt[0]; pe[1] = pe[0]; ps[1] = ps[0]; ptag[1] = ptag[0];
    pv[0] = 0;
    if (v) model(t, tag);
    in_valid = v;
    in_time = TW'(t);
    nominal_period = PW'(nom);
    cutoff_div = DW'(dv);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    check_eq("R1", "out_valid", longint'(out_valid), 0);
    check_eq("R1", "out_time", longint'(out_time), 0);
    check_eq("R1", "out_err", longint'($signed(out_err)), 0);
    check_eq("R1", "out_skip", longint'(out_skip), 0);

    tick(1, 1000, "R2");                 // first prediction is one nominal period
    tick(1, 2500, "R3");                 // exact half rounds up to 2 UI, err -500
    tick(0, 0, "R8");
    for (int i = 0; i < 20; i++)         // jittered edges, runs of 1..3 UI
      tick(1, m_clk + (1 + i % 3) * cur_p() + ((i * 37) % 201) - 100, "R4");
    for (int i = 0; i < 60; i++) begin   // constant offset: correction builds up
      tick(1, m_clk + cur_p() + 40, "R5");
      tick(0, 0, "R5");
    end
    dv = 3;                              // below the floor: acts as 20
    for (int i = 0; i < 30; i++) tick(1, m_clk + 2 * cur_p() - 60, "R6");
    dv = 0;
    for (int i = 0; i < 10; i++) tick(1, m_clk + cur_p() + 25, "R6");
    dv = 40;
    tick(1, m_clk + cur_p() / 2 - 1, "R7");               // too early
    tick(1, m_clk - 50, "R7");                            // negative distance
    tick(1, m_clk + 8 * cur_p() + cur_p() / 2 + 1, "R7"); // run too long
    tick(1, m_clk + 8 * cur_p() + cur_p() / 2 - 1, "R3"); // longest accepted run
    tick(1, m_clk + (cur_p() + 1) / 2, "R7");             // shortest accepted
    tick(0, 0, "R8");
    for (int i = 0; i < 300; i++) begin  // back-to-back and gapped edges
      int n, j;
      n = 1 + int'($urandom % 5);
      j = int'($urandom % 301) - 150;
      if ($urandom % 4 == 0) tick(0, 0, "R8");
      else tick(1, m_clk + n * cur_p() + j, "R8");
    end
    repeat (4) tick(0, 0, "R8");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule